// File: doc/BRIEF.md
# Byte FIFO pair with programmable fill triggers for a two-wire bus controller

This block sits between a processor register bus and a two-wire serial bus engine. It holds one 16-byte queue for outgoing bytes and one for incoming bytes.

Software pushes outgoing bytes by writing a single data port, and pops incoming bytes by reading the same port. The engine drains the transmit queue and fills the receive queue through byte-wide valid/ready handshakes.

A control register clears each queue on its own and sets a fill trigger for each direction. The two triggers are coded differently. Three sticky status flags report the transmit trigger, the receive trigger and transmit completion. An enable register routes these flags onto one interrupt line. While the receive-trigger flag or the completion flag is still pending, the block asks the engine to hold the bus. Software releases the bus by writing zero to those flags.

Top module: `i2c_fifo_ctl`

## Requirements
- R1: Each queue holds 16 bytes. A data-port write (address 0) while the transmit queue holds 16 bytes is dropped, and the count stays 16.
- R2: A control write (address 1) with bit 0 set empties the transmit queue, and bit 1 set empties the receive queue. Each clear is independent. Bits [7:2] are stored and read back, and bits [1:0] read as 0.
- R3: Status bit 1 (address 2) sets once the receive count is at least control field [7:4] plus one.
- R4: Status bit 0 sets while the transmit count is at or below a limit chosen by control field [3:2]: code 0 gives 8, code 1 gives 4, code 2 gives 2, code 3 gives 0.
- R5: Status bit 2 sets when the engine reports a byte fully shifted out (tx_shifted) while the transmit queue is empty. It does not set when the queue still holds data.
- R6: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. A cleared bit sets again on the next clock if its condition still holds.
- R7: The irq output is high exactly when some status bit [2:0] is set together with the matching bit of the enable register (address 3).
- R8: The eng_hold output is high while status bit 1 or status bit 2 is set.
- R9: Address 4 returns the receive count and address 5 returns the transmit count, each 0 to 16.
- R10: A data-port read returns the oldest received byte and pops it. A read with the receive queue empty returns 0 and leaves the count at 0.
- R11: eng_tx_valid is high while the transmit queue is not empty, and bytes leave in write order. eng_rx_ready is low while the receive queue is full, and a push then is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data port) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_tx_shifted | input | 1 | Engine finished shifting a byte out |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive queue has room |
| eng_hold | output | 1 | Request to stall the bus |
| irq | output | 1 | Interrupt request |

## Verification
The transmit trigger is swept through all four codes. For each code, the queue is filled exactly to the limit and then one byte past it. A wrong code mapping or an off-by-one comparison shows up as a flag that is set on the wrong side of the boundary. The receive trigger is tried one byte short of and exactly at field plus one. Completion is raised once with the transmit queue empty and once with data still queued, which separates a correct completion flag from one that ignores the fill level. Full and empty queues are driven past their limits to separate dropping from wrap-around, and the status register is written with mixed ones and zeros to confirm that only zero bits clear.

// File: rtl/i2cfq_pkg.sv
package i2cfq_pkg;
  typedef enum logic [2:0] {
    RA_DATA  = 3'd0,
    RA_CTRL  = 3'd1,
    RA_STAT  = 3'd2,
    RA_IEN   = 3'd3,
    RA_RXCNT = 3'd4,
    RA_TXCNT = 3'd5
  } reg_addr_e;

  localparam int ST_TXT  = 0;
  localparam int ST_RXT  = 1;
  localparam int ST_TEND = 2;
  localparam int NFLAG   = 3;

  // bytes-remaining limit for each transmit trigger code
  function automatic int tx_limit(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/i2cfq_fifo.sv
module i2cfq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0] count_n;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    count_n  = count;
    if (clr) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      count_n  = '0;
    end else begin
      if (push_ok) wr_ptr_n = bump(wr_ptr);
      if (pop_ok)  rd_ptr_n = bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_n = count + CW'(1);
        2'b01:   count_n = count - CW'(1);
        default: count_n = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/i2cfq_flags.sv
module i2cfq_flags
  import i2cfq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_cnt,
  input  logic [1:0]       tx_code,
  input  logic [3:0]       rx_field,
  input  logic             tx_shifted,
  input  logic             st_we,
  input  logic [NFLAG-1:0] st_wdata,
  input  logic [NFLAG-1:0] ien,
  output logic [NFLAG-1:0] status,
  output logic             irq,
  output logic             hold
);
  logic [NFLAG-1:0] set_cond, clr_mask, status_n;
  logic [CW:0]      rx_goal;

  assign rx_goal = (CW+1)'(rx_field) + (CW+1)'(1);

  always_comb begin
    set_cond          = '0;
    set_cond[ST_TXT]  = ({1'b0, tx_cnt} <= (CW+1)'(tx_limit(tx_code)));
    set_cond[ST_RXT]  = ({1'b0, rx_cnt} >= rx_goal);
    set_cond[ST_TEND] = tx_shifted & (tx_cnt == '0);
    clr_mask          = st_we ? ~st_wdata : '0;
    status_n          = (status & ~clr_mask) | set_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_n;
  end

  assign irq  = |(status & ien);
  assign hold = status[ST_RXT] | status[ST_TEND];
endmodule

// File: rtl/i2c_fifo_ctl.sv
module i2c_fifo_ctl
  import i2cfq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_valid,
  input  logic          eng_tx_ready,
  input  logic          eng_tx_shifted,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_rx_valid,
  output logic          eng_rx_ready,
  output logic          eng_hold,
  output logic          irq
);
  logic [5:0]       ctrl_q, ctrl_n;
  logic [NFLAG-1:0] ien_q, ien_n;
  logic [NFLAG-1:0] status;
  logic             data_we, data_re, ctrl_we, stat_we, ien_we;
  logic             tx_clr, rx_clr;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0]    rx_head;

  assign data_we = bus_wr & (bus_addr == RA_DATA);
  assign data_re = bus_rd & (bus_addr == RA_DATA);
  assign ctrl_we = bus_wr & (bus_addr == RA_CTRL);
  assign stat_we = bus_wr & (bus_addr == RA_STAT);
  assign ien_we  = bus_wr & (bus_addr == RA_IEN);
  assign tx_clr  = ctrl_we & bus_wdata[0];
  assign rx_clr  = ctrl_we & bus_wdata[1];

  always_comb begin
    ctrl_n = ctrl_q;
    ien_n  = ien_q;
    if (ctrl_we) ctrl_n = bus_wdata[7:2];
    if (ien_we)  ien_n  = bus_wdata[NFLAG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      ien_q  <= ien_n;
    end
  end

  i2cfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(data_we), .push_data(bus_wdata[DW-1:0]),
    .pop(eng_tx_ready), .head(eng_tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  i2cfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(eng_rx_valid), .push_data(eng_rx_data),
    .pop(data_re), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign eng_tx_valid = ~tx_empty;
  assign eng_rx_ready = ~rx_full;

  i2cfq_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .tx_code(ctrl_q[1:0]), .rx_field(ctrl_q[5:2]),
    .tx_shifted(eng_tx_shifted),
    .st_we(stat_we), .st_wdata(bus_wdata[NFLAG-1:0]),
    .ien(ien_q), .status(status), .irq(irq), .hold(eng_hold)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_DATA:  bus_rdata = rx_empty ? '0 : 8'(rx_head);
      RA_CTRL:  bus_rdata = {ctrl_q, 2'b00};
      RA_STAT:  bus_rdata = 8'(status);
      RA_IEN:   bus_rdata = 8'(ien_q);
      RA_RXCNT: bus_rdata = 8'(rx_cnt);
      RA_TXCNT: bus_rdata = 8'(tx_cnt);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2cfq_chk.sv
module i2cfq_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [2:0]    bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [5:0]    ctrl_q,
  input logic [2:0]    status,
  input logic [2:0]    ien_q,
  input logic          eng_tx_ready,
  input logic          eng_rx_valid,
  input logic          eng_rx_ready,
  input logic          irq
);
  logic ctl_wr;
  assign ctl_wr = bus_wr && bus_addr == 3'd1;

  a_r1_tx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));

  a_r1_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && tx_cnt == CW'(DEPTH) && !eng_tx_ready)
      |=> tx_cnt == CW'(DEPTH));

  a_r2_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[0]) |=> tx_cnt == '0);

  a_r2_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[1]) |=> rx_cnt == '0);

  a_r3_rx_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rx_cnt} >= (CW+1)'(ctrl_q[5:2]) + (CW+1)'(1) && !ctl_wr)
      |=> status[1]);

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien_q != '0);

  a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && rx_cnt == '0) |-> bus_rdata == 8'h00);

  a_r10_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && rx_cnt == '0 && !eng_rx_valid) |=> rx_cnt == '0);

  a_r11_rx_full_refused: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt == CW'(DEPTH) |-> !eng_rx_ready);
endmodule

bind i2c_fifo_ctl i2cfq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ctrl_q(ctrl_q), .status(status),
  .ien_q(ien_q), .eng_tx_ready(eng_tx_ready), .eng_rx_valid(eng_rx_valid),
  .eng_rx_ready(eng_rx_ready), .irq(irq)
);

// File: tb/sim_i2c_fifo_ctl.sv
module sim_i2c_fifo_ctl;
  localparam int CLK_P = 10;

  logic       clk, rst_n;
  logic       bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] eng_tx_data, eng_rx_data;
  logic       eng_tx_valid, eng_tx_ready, eng_tx_shifted;
  logic       eng_rx_valid, eng_rx_ready, eng_hold, irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  i2c_fifo_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
    .eng_tx_ready(eng_tx_ready), .eng_tx_shifted(eng_tx_shifted),
    .eng_rx_data(eng_rx_data), .eng_rx_valid(eng_rx_valid),
    .eng_rx_ready(eng_rx_ready), .eng_hold(eng_hold), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {tx code[1:0], bytes queued[4:0], expected status bit 0}
  localparam logic [7:0] TXV [8] = '{
    {2'd0, 5'd8, 1'b1}, {2'd0, 5'd9, 1'b0},
    {2'd1, 5'd4, 1'b1}, {2'd1, 5'd5, 1'b0},
    {2'd2, 5'd2, 1'b1}, {2'd2, 5'd3, 1'b0},
    {2'd3, 5'd0, 1'b1}, {2'd3, 5'd1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    eng_tx_ready = 0; eng_tx_shifted = 0; eng_rx_valid = 0; eng_rx_data = 0;
    rst_n = 0;
    idle(3);
    // reset state
    bus_addr = 3'd2; #1;
    chk("R7 reset irq", irq, 0);
    chk("R8 reset hold", eng_hold, 0);
    chk("R6 reset status", bus_rdata, 0);
    @(negedge clk); rst_n = 1;
    idle(2);
    rd(3'd2, v); chk("R4 tx empty flag after reset", v, 1);
    rd(3'd5, v); chk("R9 tx count after reset", v, 0);

    // transmit trigger table
    for (int i = 0; i < 8; i++) begin
      wr(3'd1, {4'd0, TXV[i][7:6], 2'b01});
      for (int k = 0; k < int'(TXV[i][5:1]); k++) wr(3'd0, 8'(k));
      wr(3'd2, 8'h00);
      idle(1);
      rd(3'd2, v); chk("R4 tx trigger", v[0], TXV[i][0]);
      rd(3'd5, v); chk("R9 tx count", v, TXV[i][5:1]);
    end

    // overflow and engine order
    wr(3'd1, 8'h01);
    for (int k = 0; k < 17; k++) wr(3'd0, 8'(8'h40 + k));
    rd(3'd5, v); chk("R1 full tx drops write", v, 16);
    rd(3'd1, v); chk("R2 ctrl readback", v, 0);
    chk("R11 tx valid", eng_tx_valid, 1);
    chk("R11 tx head order", eng_tx_data, 8'h40);
    @(negedge clk); eng_tx_ready = 1; @(negedge clk); eng_tx_ready = 0;
    chk("R11 tx second byte", eng_tx_data, 8'h41);
    rd(3'd5, v); chk("R11 tx count after pop", v, 15);

    // empty receive read; rx clear leaves tx alone
    wr(3'd1, {4'd3, 2'd0, 2'b10});
    rd(3'd0, v); chk("R10 empty read value", v, 0);
    rd(3'd4, v); chk("R10 empty read count", v, 0);
    rd(3'd5, v); chk("R2 tx untouched by rx clear", v, 15);
    rd(3'd1, v); chk("R2 ctrl readback field", v, 8'h30);

    // receive trigger with field 3
    wr(3'd1, {4'd3, 2'd0, 2'b01});
    rx_push(8'hA1); rx_push(8'hA2); rx_push(8'hA3);
    wr(3'd2, 8'h00); idle(1);
    rd(3'd2, v); chk("R3 below rx trigger", v[1], 0);
    chk("R8 hold idle", eng_hold, 0);
    rx_push(8'hA4); idle(1);
    rd(3'd2, v); chk("R3 at rx trigger", v[1], 1);
    chk("R8 hold on rx flag", eng_hold, 1);
    wr(3'd3, 8'h00);
    chk("R7 irq disabled", irq, 0);
    wr(3'd3, 8'h02);
    chk("R7 irq enabled", irq, 1);
    rd(3'd0, v); chk("R10 rx pop order", v, 8'hA1);
    rd(3'd4, v); chk("R9 rx count", v, 3);
    wr(3'd2, 8'h05); idle(1);
    rd(3'd2, v); chk("R6 zero bit clears", v[1], 0);
    chk("R8 hold released", eng_hold, 0);
    chk("R7 irq follows flag", irq, 0);

    // receive full
    for (int k = 0; k < 14; k++) rx_push(8'(k));
    rd(3'd4, v); chk("R11 rx full count", v, 16);
    chk("R11 rx ready low", eng_rx_ready, 0);
    rx_push(8'hEE);
    rd(3'd4, v); chk("R11 rx push refused", v, 16);

    // transmit end
    wr(3'd3, 8'h04);
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h00); idle(1);
    @(negedge clk); eng_tx_shifted = 1; @(negedge clk); eng_tx_shifted = 0;
    rd(3'd2, v); chk("R5 tend with empty tx", v[2], 1);
    chk("R8 hold on tend", eng_hold, 1);
    chk("R7 irq on tend", irq, 1);
    wr(3'd2, 8'h07);
    rd(3'd2, v); chk("R6 one bit keeps flag", v[2], 1);
    wr(3'd2, 8'h03);
    rd(3'd2, v); chk("R6 clear tend", v[2], 0);
    chk("R8 hold after tend clear", eng_hold, 0);
    wr(3'd0, 8'h55);
    @(negedge clk); eng_tx_shifted = 1; @(negedge clk); eng_tx_shifted = 0;
    rd(3'd2, v); chk("R5 no tend with data queued", v[2], 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule